// File: doc/BRIEF.md
# Serial Master with Slave Busy Handshake

This block is a clocked serial master that exchanges bytes in full duplex with one slave. The serial clock comes from the system clock through a divider of `DIV` system cycles per serial period. Each byte goes out on the data output while the slave's reply is captured on the data input. The host loads a byte with a one-cycle start strobe. The block can hold one more byte in a queue while the current byte shifts. It gives a one-cycle completion pulse together with the received byte.

Between bytes the master can pause for the slave. The slave drives a busy line that is asynchronous to the master's clock. When the busy check is enabled, the master leaves the serial clock parked high after each byte and looks at the synchronized busy level once per serial period. Each look happens where a rising edge would have fallen. Once it sees busy inactive, the master waits half a serial period, then starts the next byte or returns to idle. The busy level can be active-high or active-low. Setting interval mode turns the busy check off.

Top module: `sbm_busy_master`

## Requirements
- R1: During and after reset, and whenever the transfer flag is low, SCK is high, SO is low, the completion pulse is low, and the received-byte output reads zero until the first byte completes.
- R2: Bytes move MSB first (bit 7 down to bit 0) in both directions. SO changes only on SCK falling edges and holds while SCK is high. SI is captured on SCK rising edges. The received byte equals the 8 bits captured, with the first captured bit in bit 7.
- R3: While shifting, each SCK low phase lasts exactly DIV/2 system cycles.
- R4: The completion pulse is high for exactly one cycle. It rises in the same cycle as the 8th rising SCK edge of a byte, and the received-byte output already holds the new byte in that cycle.
- R5: A start that comes while a byte is already queued is ignored. With the busy check off, a byte queued before the decision point begins with its first falling SCK edge exactly DIV/2 cycles after the completion pulse.
- R6: The busy check applies only when busy_en is 1 and interval_mode is 0. In every other setting the busy level has no effect on timing.
- R7: With busy_pol at 0 a high busy input means busy. With busy_pol at 1 a low busy input means busy.
- R8: While busy is seen active after a byte, SCK stays high, no new byte starts and the transfer flag stays high, for any length of time.
- R9: Busy passes through a SYNC_STAGES-flop synchronizer and is examined once per serial period, at the rising-edge positions. The next falling edge comes DIV/2 cycles after an inactive sample. If busy is already inactive, the first falling edge of a queued byte comes 1.5·DIV cycles after the completion pulse. After busy is released, the first falling edge comes within DIV + DIV/2 + 4 cycles.
- R10: When no byte is queued, the transfer flag drops and SO goes low at the point where the next byte would have started. With the busy check on and busy inactive, that point is 1.5·DIV cycles after the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that queues wdata |
| wdata | input | DATA_W | Byte to transmit |
| rdata | output | DATA_W | Last received byte |
| irq | output | 1 | One-cycle pulse per completed byte |
| xfer | output | 1 | Transfer in progress (includes busy wait) |
| busy_en | input | 1 | Enable the busy check between bytes |
| busy_pol | input | 1 | Busy polarity: 0 active-high, 1 active-low |
| interval_mode | input | 1 | Interval mode; overrides and disables the busy check |
| sck | output | 1 | Serial clock, idles high |
| so | output | 1 | Serial data out |
| si | input | 1 | Serial data in |
| busy | input | 1 | Asynchronous busy line from slave |

## Verification
The exchange is tried with edge-valued bytes (single-bit and alternating patterns) against different slave replies, so that a bit-order or capture-edge error shows up in one direction or the other. Inter-byte gaps are measured in four settings: busy check off, busy check on with busy idle, busy held active and then released, and busy active under interval mode. Between them these settings separate the half-period chaining, the 1.5-period restart, the stall, and the override rules. An inverted-polarity run separates the two active levels. A triple start checks that a second queued byte is dropped.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOW,
      ST_HIGH,
      ST_WAIT,
      ST_GAP
   } sbm_state_e;
endpackage

// File: rtl/sbm_sync.sv
module sbm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sbm_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/sbm_shifter.sv
module sbm_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_data,
   input  logic         capture,
   input  logic         last,
   input  logic         si,
   output logic         msb,
   output logic [W-1:0] rdata
);
   logic [W-1:0] sh;
   logic [W-1:0] sh_next;

   assign sh_next = {sh[W-2:0], si};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         rdata <= '0;
      end else begin
         if (load)         sh    <= load_data;
         else if (capture) sh    <= sh_next;
         if (capture && last) rdata <= sh_next;
      end
   end

   assign msb = sh[W-1];
endmodule

// File: rtl/sbm_busy_master.sv
module sbm_busy_master #(
   parameter int DATA_W      = 8,
   parameter int DIV         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq,
   output logic              xfer,
   input  logic              busy_en,
   input  logic              busy_pol,
   input  logic              interval_mode,
   output logic              sck,
   output logic              so,
   input  logic              si,
   input  logic              busy
);
   import sbm_pkg::*;

   localparam int HALF  = DIV / 2;
   localparam int CNT_W = $clog2(DIV);
   localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF - 1);
   localparam logic [CNT_W-1:0] PER_END  = CNT_W'(DIV - 1);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

   if (DIV < 4 || (DIV % 2) != 0) begin : g_bad_div
      $error("sbm_busy_master: DIV must be even and at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("sbm_busy_master: DATA_W must be at least 2");
   end

   sbm_state_e        st;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bcnt;
   logic              pend;
   logic [DATA_W-1:0] nbuf;
   logic              busy_s;
   logic              busy_act;
   logic              busy_chk;
   logic              half_end;
   logic              last_bit;
   logic              load;
   logic              capture;
   logic              sh_msb;

   sbm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (busy),
      .dout (busy_s)
   );

   assign busy_act = busy_s ^ busy_pol;
   assign busy_chk = busy_en & ~interval_mode;
   assign half_end = (cnt == HALF_END);
   assign last_bit = (bcnt == LAST_BIT);
   assign capture  = (st == ST_LOW) && half_end;
   assign load     = pend && ((st == ST_IDLE) ||
                              ((st == ST_GAP) && half_end) ||
                              ((st == ST_HIGH) && half_end && last_bit && !busy_chk));

   sbm_shifter #(.W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_data(nbuf),
      .capture  (capture),
      .last     (last_bit),
      .si       (si),
      .msb      (sh_msb),
      .rdata    (rdata)
   );

   assign xfer = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         bcnt <= '0;
         sck  <= 1'b1;
         so   <= 1'b0;
         irq  <= 1'b0;
         pend <= 1'b0;
         nbuf <= '0;
      end else begin
         irq <= 1'b0;
         if (load) pend <= 1'b0;
         if (start && !pend) begin
            pend <= 1'b1;
            nbuf <= wdata;
         end
         if (load) begin
            st   <= ST_LOW;
            sck  <= 1'b0;
            so   <= nbuf[DATA_W-1];
            cnt  <= '0;
            bcnt <= '0;
         end else begin
            case (st)
               ST_IDLE: cnt <= '0;
               ST_LOW: begin
                  if (half_end) begin
                     st  <= ST_HIGH;
                     sck <= 1'b1;
                     cnt <= '0;
                     if (last_bit) irq <= 1'b1;
                  end else cnt <= cnt + CNT_W'(1);
               end
               ST_HIGH: begin
                  if (half_end) begin
                     cnt <= '0;
                     if (!last_bit) begin
                        st   <= ST_LOW;
                        sck  <= 1'b0;
                        so   <= sh_msb;
                        bcnt <= bcnt + BIT_W'(1);
                     end else if (busy_chk) begin
                        st <= ST_WAIT;
                     end else begin
                        st <= ST_IDLE;
                        so <= 1'b0;
                     end
                  end else cnt <= cnt + CNT_W'(1);
               end
               ST_WAIT: begin
                  if (half_end && !busy_act) begin
                     st  <= ST_GAP;
                     cnt <= '0;
                  end else if (cnt == PER_END) cnt <= '0;
                  else cnt <= cnt + CNT_W'(1);
               end
               ST_GAP: begin
                  if (half_end) begin
                     st  <= ST_IDLE;
                     so  <= 1'b0;
                     cnt <= '0;
                  end else cnt <= cnt + CNT_W'(1);
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer |-> (sck && !so && !irq));

   assert_so_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck) && xfer && $past(xfer)) |-> $stable(so));

   assert_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sck) |=> !sck);

   assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   assert_irq_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $rose(sck));

   assert_wait_parked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WAIT) |-> (sck && xfer));

   assert_wait_needs_check_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_HIGH && st == ST_WAIT) |-> $past(busy_chk));
endmodule

// File: tb/sbm_busy_master_tb_top.sv
module sbm_busy_master_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DIV  = 8;
   localparam int HALF = DIV / 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq, xfer, sck, so;
   logic       busy_en = 1'b0, busy_pol = 1'b0, interval_mode = 1'b0;
   logic       si = 1'b0, busy = 1'b0;

   int vectors = 0, fails = 0;
   int cyc = 0, irq_cyc = 0, irq_count = 0, fall_cyc = 0;
   int gap = -1, xfer_fall_gap = -1, low_run = 0, slave_bytes = 0;
   bit after_irq = 0, gap_seen = 0, prev_sck = 1, prev_xfer = 0;
   byte unsigned exp_rx[$], exp_tx[$], slave_q[$];
   byte unsigned sreg = 0, srx = 0;
   int sbit = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbm_busy_master #(.DATA_W(8), .DIV(DIV), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .wdata(wdata), .rdata(rdata),
      .irq(irq), .xfer(xfer), .busy_en(busy_en), .busy_pol(busy_pol),
      .interval_mode(interval_mode), .sck(sck), .so(so), .si(si), .busy(busy)
   );

   task automatic check(bit ok, string req, int act, int exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected completion", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   // monitor: scoreboard pop, gap and phase measurements
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq) begin
            if (exp_rx.size() == 0) check(0, "R4 unexpected pulse", 1, 0);
            else begin
               byte unsigned e;
               e = exp_rx.pop_front();
               check(rdata == e, "R2/R4 rdata", rdata, e);
            end
            irq_cyc = cyc;
            irq_count++;
            after_irq = 1;
         end
         if (!sck) low_run++;
         if (prev_sck && !sck && after_irq) begin
            gap = cyc - irq_cyc;
            fall_cyc = cyc;
            after_irq = 0;
            gap_seen = 1;
         end
         if (!prev_sck && sck) begin
            check(low_run == HALF, "R3 low phase", low_run, HALF);
            low_run = 0;
         end
         if (prev_xfer && !xfer) begin
            xfer_fall_gap = cyc - irq_cyc;
            after_irq = 0;
         end
         prev_sck = sck;
         prev_xfer = xfer;
      end
   end

   // slave model: drives SI on falling SCK, captures SO on rising SCK
   always @(negedge sck) if (rst_n) begin
      if (sbit == 0) sreg = (slave_q.size() != 0) ? slave_q.pop_front() : 8'hFF;
      si <= sreg[7-sbit];
   end

   always @(posedge sck) if (rst_n && xfer) begin
      srx = {srx[6:0], so};
      sbit++;
      if (sbit == 8) begin
         byte unsigned e;
         e = (exp_tx.size() != 0) ? exp_tx.pop_front() : 8'h00;
         check(srx == e, "R2 slave received", srx, e);
         sbit = 0;
         slave_bytes++;
      end
   end

   task automatic push_byte(byte unsigned m, byte unsigned s);
      @(negedge clk);
      start = 1'b1;
      wdata = m;
      exp_rx.push_back(s);
      exp_tx.push_back(m);
      slave_q.push_back(s);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic raw_start(byte unsigned m);
      @(negedge clk);
      start = 1'b1;
      wdata = m;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      repeat (2) @(negedge clk);
      while (xfer && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_irq(int target);
      int n = 0;
      while (irq_count < target && n < 20000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic chain_pair(byte unsigned m1, byte unsigned s1, byte unsigned m2, byte unsigned s2);
      gap_seen = 0;
      gap = -1;
      push_byte(m1, s1);
      repeat (3) @(negedge clk);
      push_byte(m2, s2);
   endtask

   initial begin
      int base;
      int rel;
      repeat (3) @(negedge clk);
      check(sck == 1'b1, "R1 sck reset", sck, 1);
      check(so == 1'b0, "R1 so reset", so, 0);
      check(xfer == 1'b0 && irq == 1'b0, "R1 flags reset", {xfer, irq}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(rdata == 8'h00 && sck == 1'b1, "R1 after release", rdata, 0);

      // single bytes, edge patterns (R2, R3, R4)
      push_byte(8'hA5, 8'h3C); wait_idle();
      push_byte(8'h80, 8'h01); wait_idle();
      push_byte(8'h01, 8'h80); wait_idle();
      check(so == 1'b0 && xfer == 1'b0, "R10 so low when idle", so, 0);

      // chaining, busy check off, third start ignored (R5)
      base = slave_bytes;
      chain_pair(8'h5A, 8'hC3, 8'hF0, 8'h0F);
      raw_start(8'h77);
      wait_idle();
      check(gap == HALF, "R5 chained gap", gap, HALF);
      check(slave_bytes - base == 2, "R5 extra start ignored", slave_bytes - base, 2);
      check(exp_rx.size() == 0, "R5 scoreboard drained", exp_rx.size(), 0);

      // busy check on, busy idle (R9, R10)
      busy_en = 1'b1; busy_pol = 1'b0; busy = 1'b0;
      chain_pair(8'h33, 8'hAA, 8'hCC, 8'h55);
      wait_idle();
      check(gap == DIV + HALF, "R9 restart after idle busy", gap, DIV + HALF);
      check(xfer_fall_gap == DIV + HALF, "R10 flag drop point", xfer_fall_gap, DIV + HALF);

      // busy active high, stall then release (R8, R9)
      busy = 1'b1;
      repeat (4) @(negedge clk);
      base = irq_count;
      chain_pair(8'h96, 8'h69, 8'h3E, 8'hE3);
      wait_irq(base + 1);
      repeat (10 * DIV) @(negedge clk);
      check(xfer == 1'b1, "R8 flag held during stall", xfer, 1);
      check(gap_seen == 0 && sck == 1'b1, "R8 no falling edge during stall", gap_seen, 0);
      @(negedge clk);
      busy = 1'b0;
      rel = cyc;
      begin
         int n = 0;
         while (!gap_seen && n < 1000) begin @(negedge clk); n++; end
      end
      check(gap_seen && (fall_cyc - rel) >= HALF && (fall_cyc - rel) <= DIV + HALF + 4,
            "R9 release latency", fall_cyc - rel, DIV + HALF);
      wait_idle();

      // inverted polarity: low means busy (R7)
      busy_pol = 1'b1; busy = 1'b0;
      repeat (4) @(negedge clk);
      base = irq_count;
      chain_pair(8'h11, 8'h22, 8'h44, 8'h88);
      wait_irq(base + 1);
      repeat (6 * DIV) @(negedge clk);
      check(gap_seen == 0 && xfer == 1'b1, "R7 low level stalls when inverted", gap_seen, 0);
      @(negedge clk);
      busy = 1'b1;
      wait_idle();
      check(gap_seen == 1 && exp_rx.size() == 0, "R7 high level releases when inverted", gap_seen, 1);

      // interval mode overrides busy check (R6)
      busy_pol = 1'b0; busy = 1'b1; interval_mode = 1'b1;
      repeat (4) @(negedge clk);
      chain_pair(8'hDE, 8'hAD, 8'hBE, 8'hEF);
      wait_idle();
      check(gap == HALF, "R6 interval mode ignores busy", gap, HALF);

      // busy check disabled (R6)
      interval_mode = 1'b0; busy_en = 1'b0;
      chain_pair(8'h0F, 8'hF0, 8'hE1, 8'h1E);
      wait_idle();
      check(gap == HALF, "R6 busy_en low ignores busy", gap, HALF);
      check(exp_rx.size() == 0 && exp_tx.size() == 0, "R2 all bytes exchanged",
            exp_rx.size() + exp_tx.size(), 0);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule